// File: doc/BRIEF.md
# Microprogram Sequencer with Flag Branch and Opcode Dispatch

This block is the control section of a microcoded processor. It holds a 512-word control store of 36-bit microinstructions, a 9-bit microprogram counter (`upc`) and a microinstruction register. It has no incrementer. Each microinstruction names its own successor. Three jump bits then decide how that successor is changed before it is loaded.

The successor field can be used as is (mode `SEL_DIRECT`). A taken flag test forces bit 8 high, which adds 0x100 to a target at or below 0xFF (mode `SEL_BRANCH`). With the dispatch bit set, the opcode byte is ORed into bits 7:0, so each opcode starts its own microroutine (mode `SEL_DISPATCH`). A taken flag test and dispatch can apply together (mode `SEL_DISPATCH_BRANCH`).

Timing follows the two clock edges. On the rising edge the counter takes the computed successor, using the N and Z flags and the opcode byte present at that edge. On the falling edge the register loads the store word addressed by the counter. The fields of that word are then driven to the datapath: ALU control, register write enables, memory strobes and a decoded one-hot B-bus source enable. The store is filled through a simple write port.

Top module: `mseq_top`

## Requirements
- R1: The microinstruction word is laid out as follows, from the top bit down:
  - [35:27] successor address.
  - [26] dispatch bit.
  - [25] branch-on-N enable.
  - [24] branch-on-Z enable.
  - [23:16] ALU control.
  - [15:7] register write enables.
  - [6] memory write, [5] memory read, [4] byte fetch.
  - [3:0] B-source select.
- R2: A rising edge with `rst_n` low sets `upc` to 0. The following falling edge loads the word at address 0 into the register.
- R3: When all three jump bits are 0, the rising edge loads `upc` with the successor field unchanged.
- R4: The new `upc[8]` equals succ[8] | (brz & `flag_z`) | (brn & `flag_n`), with both flags sampled at that rising edge. A taken test from a successor of 0xFF or below therefore lands at successor + 0x100.
- R5: When the dispatch bit is 1, the new `upc[7:0]` is succ[7:0] | `opc_byte`. When it is 0, the new `upc[7:0]` is succ[7:0]. This combines with R4.
- R6: Each falling edge loads the register with the store word at `upc`. `alu_ctl`, `c_wen`, `mem_write`, `mem_read` and `mem_fetch` show its fields until the next falling edge.
- R7: `b_en` has exactly bit s set when the select s is below 9, and is all zero for selects 9 to 15.
- R8: With `ld_en` high at a rising edge, `ld_data` is written at `ld_addr`. A falling edge after that reads the new word.
- R9: Changes on `flag_n`, `flag_z` and `opc_byte` between rising edges leave `upc` and the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge advances `upc`, falling edge loads the register |
| rst_n | input | 1 | Synchronous active-low reset of `upc` |
| ld_en | input | 1 | Control store write strobe |
| ld_addr | input | 9 | Control store write address |
| ld_data | input | 36 | Control store write word |
| flag_n | input | 1 | Negative flag from the datapath ALU |
| flag_z | input | 1 | Zero flag from the datapath ALU |
| opc_byte | input | 8 | Opcode byte from the instruction byte buffer |
| upc | output | 9 | Microprogram counter |
| alu_ctl | output | 8 | ALU control field |
| c_wen | output | 9 | Register write enables from the result bus |
| mem_write | output | 1 | Memory word write strobe |
| mem_read | output | 1 | Memory word read strobe |
| mem_fetch | output | 1 | Instruction byte fetch strobe |
| b_en | output | 16 | One-hot B-bus source enable |

## Verification
The hardest condition to reach from the ports is placing an arbitrary microinstruction in the register together with a chosen flag and opcode state at the next rising edge. Normally a word only gets there when the microprogram jumps to it.

The bench avoids this. It holds reset, writes the test word at address 0, and lets a falling edge load that word into the register. It then releases reset with the chosen flags and byte applied. This gives a near-exhaustive sweep over all jump-bit codes, both flags, successors around the 0xFF/0x100 boundary and several opcode bytes. After each step the bench toggles the inputs between edges, which checks R9.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int ADDR_W = 9;
    localparam int ALU_W  = 8;
    localparam int CW_W   = 9;
    localparam int BSEL_W = 4;
    localparam int OPC_W  = 8;
    localparam int UI_W   = ADDR_W + 3 + ALU_W + CW_W + 3 + BSEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] succ;
        logic              disp;
        logic              brn;
        logic              brz;
        logic [ALU_W-1:0]  alu;
        logic [CW_W-1:0]   cwen;
        logic              mwr;
        logic              mrd;
        logic              mfetch;
        logic [BSEL_W-1:0] bsel;
    } uinst_t;

    typedef enum logic [1:0] {
        SEL_DIRECT,
        SEL_BRANCH,
        SEL_DISPATCH,
        SEL_DISPATCH_BRANCH
    } nxt_sel_e;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  uinst_t             ui,
    input  logic               n,
    input  logic               z,
    input  logic [OPC_W-1:0]   opc,
    output logic [ADDR_W-1:0]  nxt
);
    localparam int LO_W = ADDR_W - 1;

    nxt_sel_e          sel;
    logic              taken;
    logic [LO_W-1:0]   lo_disp;

    assign taken   = (ui.brn & n) | (ui.brz & z);
    assign lo_disp = ui.succ[LO_W-1:0] | LO_W'(opc);

    always_comb begin
        unique case ({ui.disp, taken})
            2'b00:   sel = SEL_DIRECT;
            2'b01:   sel = SEL_BRANCH;
            2'b10:   sel = SEL_DISPATCH;
            default: sel = SEL_DISPATCH_BRANCH;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_DIRECT:          nxt = ui.succ;
            SEL_BRANCH:          nxt = {1'b1, ui.succ[LO_W-1:0]};
            SEL_DISPATCH:        nxt = {ui.succ[ADDR_W-1], lo_disp};
            SEL_DISPATCH_BRANCH: nxt = {1'b1, lo_disp};
            default:             nxt = ui.succ;
        endcase
    end
endmodule

// File: rtl/mseq_bdec.sv
module mseq_bdec #(
    parameter int SEL_W   = 4,
    parameter int SOURCES = 9
) (
    input  logic [SEL_W-1:0]        sel,
    output logic [(1<<SEL_W)-1:0]   en
);
    localparam int OUTS = 1 << SEL_W;

    for (genvar i = 0; i < OUTS; i++) begin : g_src
        if (i < SOURCES) begin : g_live
            assign en[i] = (sel == SEL_W'(i));
        end else begin : g_dead
            assign en[i] = 1'b0;
        end
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int B_SOURCES = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en,
    input  logic [ADDR_W-1:0]     ld_addr,
    input  logic [UI_W-1:0]       ld_data,
    input  logic                  flag_n,
    input  logic                  flag_z,
    input  logic [OPC_W-1:0]      opc_byte,
    output logic [ADDR_W-1:0]     upc,
    output logic [ALU_W-1:0]      alu_ctl,
    output logic [CW_W-1:0]       c_wen,
    output logic                  mem_write,
    output logic                  mem_read,
    output logic                  mem_fetch,
    output logic [(1<<BSEL_W)-1:0] b_en
);
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] upc_d;
    logic [UI_W-1:0]   store_rd;
    uinst_t            mir_q;

    mseq_store #(.AW(ADDR_W), .DW(UI_W)) u_store (
        .clk   (clk),
        .we    (ld_en),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (upc_q),
        .rdata (store_rd)
    );

    mseq_next u_next (
        .ui  (mir_q),
        .n   (flag_n),
        .z   (flag_z),
        .opc (opc_byte),
        .nxt (upc_d)
    );

    mseq_bdec #(.SEL_W(BSEL_W), .SOURCES(B_SOURCES)) u_bdec (
        .sel (mir_q.bsel),
        .en  (b_en)
    );

    // counter register: rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q <= '0;
        end else begin
            upc_q <= upc_d;
        end
    end

    // microinstruction register: falling edge
    always_ff @(negedge clk) begin
        mir_q <= uinst_t'(store_rd);
    end

    assign upc       = upc_q;
    assign alu_ctl   = mir_q.alu;
    assign c_wen     = mir_q.cwen;
    assign mem_write = mir_q.mwr;
    assign mem_read  = mir_q.mrd;
    assign mem_fetch = mir_q.mfetch;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
    import mseq_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input uinst_t                 mir,
    input logic [ADDR_W-1:0]      upc,
    input logic                   flag_n,
    input logic                   flag_z,
    input logic [OPC_W-1:0]       opc_byte,
    input logic [(1<<BSEL_W)-1:0] b_en
);
    assert_reset_zero_R2: assert property (@(posedge clk)
        !rst_n |=> (upc == '0));

    assert_direct_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir.disp && !mir.brn && !mir.brz) |=> (upc == $past(mir.succ)));

    assert_zflag_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir.disp && mir.brz && flag_z) |=> (upc == ($past(mir.succ) | 9'h100)));

    assert_opcode_dispatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mir.disp && !(mir.brn && flag_n) && !(mir.brz && flag_z))
        |=> (upc == {$past(mir.succ[ADDR_W-1]), $past(mir.succ[7:0]) | $past(opc_byte)}));

    assert_bsel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_en));
endmodule

bind mseq_top mseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mir      (mir_q),
    .upc      (upc_q),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .opc_byte (opc_byte),
    .b_en     (b_en)
);

// File: tb/sim_mseq_top.sv
module sim_mseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [35:0] ld_data = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic [7:0]  opc_byte = '0;
    logic [8:0]  upc;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_wen;
    logic        mem_write, mem_read, mem_fetch;
    logic [15:0] b_en;

    int nchk = 0;
    int nerr = 0;
    logic [35:0] shadow [512];

    always #10 clk = ~clk;

    mseq_top u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .flag_n(flag_n), .flag_z(flag_z), .opc_byte(opc_byte), .upc(upc),
        .alu_ctl(alu_ctl), .c_wen(c_wen), .mem_write(mem_write), .mem_read(mem_read),
        .mem_fetch(mem_fetch), .b_en(b_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(input int a);
        logic [8:0] nx;
        nx = 9'((a * 37 + 11) % 512);
        return {nx, 3'b000, 8'(a * 7 + 3), 9'(a ^ 'h155), 3'(a), 4'(a % 16)};
    endfunction

    function automatic logic [15:0] bexp(input logic [3:0] s);
        return (s < 4'd9) ? (16'h1 << s) : 16'h0;
    endfunction

    // R6 R7 R1: register fields against the word at address a
    task automatic chk_mir(input logic [8:0] a);
        logic [35:0] w;
        w = shadow[a];
        chk("R6 alu_ctl", 64'(alu_ctl), 64'(w[23:16]));
        chk("R6 c_wen", 64'(c_wen), 64'(w[15:7]));
        chk("R6 mem", 64'({mem_write, mem_read, mem_fetch}), 64'(w[6:4]));
        chk("R7 b_en", 64'(b_en), 64'(bexp(w[3:0])));
    endtask

    task automatic write_word(input logic [8:0] a, input logic [35:0] w);
        @(posedge clk); #2;
        ld_en = 1'b1; ld_addr = a; ld_data = w; shadow[a] = w;
        @(posedge clk); #2;
        ld_en = 1'b0;
    endtask

    task automatic run_case(input logic [2:0] jam, input logic n, input logic z,
                            input logic [8:0] addr, input logic [7:0] mbr);
        logic [35:0] w;
        logic [8:0]  exp;
        w = {addr, jam, 8'(addr + 9'(jam)), ~addr, jam, mbr[3:0]};
        @(posedge clk); #2;
        rst_n = 1'b0;
        write_word(9'd0, w);
        chk("R2 upc in reset", 64'(upc), 64'd0);
        @(negedge clk); #2;
        chk("R8 R2 loaded word at 0", 64'(alu_ctl), 64'(w[23:16]));
        rst_n = 1'b1; flag_n = n; flag_z = z; opc_byte = mbr;
        exp[7:0] = jam[2] ? (addr[7:0] | mbr) : addr[7:0];
        exp[8]   = addr[8] | (jam[0] & z) | (jam[1] & n);
        @(posedge clk); #2;
        if (jam == 3'b000)  chk("R3 direct successor", 64'(upc), 64'(exp));
        else if (jam[2])    chk("R5 R4 dispatch", 64'(upc), 64'(exp));
        else                chk("R4 flag branch", 64'(upc), 64'(exp));
        flag_n = ~n; flag_z = ~z; opc_byte = ~mbr;
        @(negedge clk); #2;
        chk("R9 upc stable between edges", 64'(upc), 64'(exp));
        chk_mir(exp);
    endtask

    initial begin
        #(20 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog act=running exp=done");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [8:0] addrs [5];
        logic [7:0] bytes [4];
        logic [8:0] cur;
        addrs[0] = 9'h000; addrs[1] = 9'h092; addrs[2] = 9'h0FF;
        addrs[3] = 9'h100; addrs[4] = 9'h1A5;
        bytes[0] = 8'h00; bytes[1] = 8'h10; bytes[2] = 8'hFF; bytes[3] = 8'h5A;

        // R8: fill the whole store under reset
        for (int a = 0; a < 512; a++) begin
            @(posedge clk); #2;
            ld_en = 1'b1; ld_addr = 9'(a); ld_data = pat(a); shadow[a] = pat(a);
        end
        @(posedge clk); #2;
        ld_en = 1'b0;
        chk("R2 upc held at zero", 64'(upc), 64'd0);

        // R3 R4 R5 R9 sweep
        for (int j = 0; j < 8; j++)
            for (int f = 0; f < 4; f++)
                for (int ai = 0; ai < 5; ai++)
                    for (int bi = 0; bi < 4; bi++)
                        run_case(3'(j), f[1], f[0], addrs[ai], bytes[bi]);

        // R3 R6: free-running chain of direct successors
        @(posedge clk); #2;
        rst_n = 1'b0;
        write_word(9'd0, pat(0));
        @(negedge clk); #2;
        rst_n = 1'b1;
        cur = 9'd0;
        for (int k = 0; k < 40; k++) begin
            cur = shadow[cur][35:27];
            @(posedge clk); #2;
            chk("R3 chain successor", 64'(upc), 64'(cur));
            @(negedge clk); #2;
            chk_mir(cur);
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule